// File: doc/BRIEF.md
# Fault-First Vector Load Sequencer

The sequencer runs one vector load instruction as a burst of element reads. Software gives it a base address, a signed element stride and a requested element count, then pulses `start_i`. The block sends one read per element, in ascending element order, on a simple request/response memory port. It keeps exactly one request in flight. Each good response is passed on as a register-file write that carries the element index and data.

Each response carries a fault flag. A fault on element 0 is a real trap: the block ends with `trap_o` set and a count of zero. A fault on any later element is not a trap. It cuts the vector length at that element, and the block reports how many elements actually loaded. The requested count is therefore only an upper bound. A request of zero elements finishes at once and makes no memory access.

The controller has four states. IDLE waits for a start. ISSUE drives the single request. WAIT holds until the response arrives. FINISH pulses done. The transitions are:
- IDLE→ISSUE: start with a non-zero count.
- IDLE→FINISH: start with a zero count.
- ISSUE→WAIT: always, after one cycle.
- WAIT→ISSUE: good response and more elements remain.
- WAIT→FINISH: good response for the last element, or any faulted response.
- FINISH→IDLE: always, after one cycle.

Top module: `vfload_seq`

## Requirements
- R1: A start accepted in IDLE with a non-zero count drives `mem_req_o` high in the cycle after the start edge, with `mem_addr_o` equal to the base address.
- R2: The request for element k carries address base + k·stride, modulo 2^ADDR_W. The stride is two's complement, so a negative stride walks downward.
- R3: Requests go out one at a time, in ascending element order. `mem_req_o` is a one-cycle pulse and does not rise again until the response for the previous request has arrived.
- R4: Each non-faulted response for element k gives exactly one write in the following cycle, with `wr_idx_o` = k and `wr_data_o` equal to the response data.
- R5: If all N requested elements load without fault, `done_o` pulses with `count_o` = N and `trap_o` = 0. The pulse comes in the same cycle as the last write.
- R6: A fault on element 0 ends the burst with `trap_o` = 1 and `count_o` = 0. No write takes place.
- R7: A fault on element k>0 ends the burst with `count_o` = k and `trap_o` = 0. There is no write for element k, and no request for any element after k.
- R8: A start with a requested count of 0 makes no memory request. `done_o` pulses in the cycle after the start edge, with `count_o` = 0 and `trap_o` = 0.
- R9: `done_o` is high for exactly one cycle. `count_o` and `trap_o` keep their values after done until the next accepted start.
- R10: `start_i` has no effect while a burst is in progress. The running burst keeps its addresses, writes and final count.
- R11: After reset, `mem_req_o`, `wr_en_o`, `done_o` and `trap_o` are 0, and `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse. Accepted only in IDLE |
| base_addr_i | input | ADDR_W | Address of element 0 |
| stride_i | input | ADDR_W | Two's-complement step between elements |
| req_count_i | input | CNT_W | Requested element count (upper bound) |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | ADDR_W | Read address, valid with `mem_req_o` |
| mem_rsp_valid_i | input | 1 | Response strobe |
| mem_rsp_data_i | input | DATA_W | Response data |
| mem_rsp_fault_i | input | 1 | Response faulted |
| wr_en_o | output | 1 | Element register write enable |
| wr_idx_o | output | CNT_W | Element index of the write |
| wr_data_o | output | DATA_W | Element data of the write |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | CNT_W | Number of elements loaded |
| trap_o | output | 1 | Element 0 faulted |

## Verification
A wrong element index or a wrong running address shows up on the very next request. The scoreboard compares every `mem_addr_o` against base + k·stride as it appears. A controller that misses the fault rule shows up within one response. Either an extra request or write follows a faulted element, or the count or trap value at `done_o` is wrong in the cycle the burst closes. A controller that accepts `start_i` while busy changes the request stream of the burst already running, and the scoreboard sees this at the next request.

// File: rtl/vfl_pkg.sv
package vfl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } vfl_state_e;
endpackage

// File: rtl/vfl_addr_gen.sv
module vfl_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    // Running address: one adder in place of an index multiplier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
        end else if (step_i) begin
            addr_q   <= addr_q + stride_q;
        end
    end

    assign addr_o = addr_q;

    // R2: address only moves on a load or a step
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o));
endmodule

// File: rtl/vfl_ctrl.sv
module vfl_ctrl
    import vfl_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] req_count_i,
    input  logic             rsp_valid_i,
    input  logic             rsp_fault_i,
    output logic             load_o,
    output logic             step_o,
    output logic             mem_req_o,
    output logic             accept_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             trap_o
);
    vfl_state_e state_q, state_d;
    logic [CNT_W-1:0] idx_q, req_q, count_q;
    logic             trap_q;
    logic             last_elem;

    assign last_elem = (CNT_W'(idx_q + 1'b1) == req_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (req_count_i == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (rsp_valid_i) state_d = (rsp_fault_i || last_elem) ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            req_q   <= '0;
            count_q <= '0;
            trap_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    idx_q   <= '0;
                    req_q   <= req_count_i;
                    count_q <= '0;
                    trap_q  <= 1'b0;
                end
                ST_WAIT: if (rsp_valid_i) begin
                    if (rsp_fault_i) begin
                        count_q <= idx_q;
                        trap_q  <= (idx_q == '0);
                    end else begin
                        idx_q <= CNT_W'(idx_q + 1'b1);
                        if (last_elem) count_q <= CNT_W'(idx_q + 1'b1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        load_o    = 1'b0;
        step_o    = 1'b0;
        mem_req_o = 1'b0;
        accept_o  = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o    = start_i;
            ST_ISSUE:  mem_req_o = 1'b1;
            ST_WAIT: begin
                step_o   = rsp_valid_i && !rsp_fault_i;
                accept_o = rsp_valid_i && !rsp_fault_i;
            end
            ST_FINISH: done_o    = 1'b1;
            default: ;
        endcase
    end

    assign idx_o   = idx_q;
    assign count_o = count_q;
    assign trap_o  = trap_q;

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !rsp_valid_i) |=> !mem_req_o);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_trap_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && trap_o) |-> (count_o == '0));
    assert_empty_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && req_count_i == '0) |=> (done_o && !mem_req_o));
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o <= req_q));
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> ($stable(count_o) && $stable(trap_o)));
endmodule

// File: rtl/vfl_wb.sv
module vfl_wb #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_en_o,
    output logic [CNT_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= accept_i;
            if (accept_i) begin
                wr_idx_o  <= idx_i;
                wr_data_o <= data_i;
            end
        end
    end
endmodule

// File: rtl/vfload_seq.sv
module vfload_seq #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int MAX_ELEMS = 64,
    localparam int CNT_W    = $clog2(MAX_ELEMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [CNT_W-1:0]  req_count_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_fault_i,
    output logic              wr_en_o,
    output logic [CNT_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              trap_o
);
    logic             load_w, step_w, accept_w;
    logic [CNT_W-1:0] idx_w;

    vfl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_count_i (req_count_i),
        .rsp_valid_i (mem_rsp_valid_i),
        .rsp_fault_i (mem_rsp_fault_i),
        .load_o      (load_w),
        .step_o      (step_w),
        .mem_req_o   (mem_req_o),
        .accept_o    (accept_w),
        .idx_o       (idx_w),
        .done_o      (done_o),
        .count_o     (count_o),
        .trap_o      (trap_o)
    );

    vfl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .base_i   (base_addr_i),
        .stride_i (stride_i),
        .step_i   (step_w),
        .addr_o   (mem_addr_o)
    );

    vfl_wb #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept_w),
        .idx_i     (idx_w),
        .data_i    (mem_rsp_data_i),
        .wr_en_o   (wr_en_o),
        .wr_idx_o  (wr_idx_o),
        .wr_data_o (wr_data_o)
    );

    // R4: a write always follows a good response one cycle earlier
    assert_write_after_good_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(mem_rsp_valid_i && !mem_rsp_fault_i));
    // R7: a faulted response is never turned into a write
    assert_no_write_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid_i && mem_rsp_fault_i) |=> !wr_en_o);
endmodule

// File: tb/vfload_seq_tb.sv
`timescale 1ns/1ps
module vfload_seq_tb;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0, stride_i = '0;
    logic [CW-1:0] req_count_i = '0;
    logic mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic mem_rsp_valid_i = 1'b0;
    logic [DW-1:0] mem_rsp_data_i = '0;
    logic mem_rsp_fault_i = 1'b0;
    logic wr_en_o;
    logic [CW-1:0] wr_idx_o;
    logic [DW-1:0] wr_data_o;
    logic done_o;
    logic [CW-1:0] count_o;
    logic trap_o;

    int n_checks = 0, n_fail = 0;
    logic [AW-1:0] addr_q[$];
    int            idx_q[$];
    logic [DW-1:0] dat_q[$];
    bit            fault_en = 0;
    logic [AW-1:0] fault_addr = '0;
    int            lat = 1;

    always #2.5 clk = ~clk;

    vfload_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .stride_i(stride_i), .req_count_i(req_count_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_fault_i(mem_rsp_fault_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .done_o(done_o), .count_o(count_o), .trap_o(trap_o)
    );

    function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_0000, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Memory model: answers each request after lat cycles
    int pend = 0;
    logic [AW-1:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid_i = 1'b0;
        mem_rsp_fault_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = mdata(pend_addr);
                mem_rsp_fault_i = fault_en && (pend_addr == fault_addr);
            end
        end
        if (mem_req_o) begin
            pend      = lat;
            pend_addr = mem_addr_o;
        end
    end

    // Monitor: pops and compares scoreboard items
    always @(negedge clk) begin
        if (rst_n && mem_req_o) begin
            if (addr_q.size() == 0) chk(0, "R7", "unexpected request", mem_addr_o, 0);
            else begin
                logic [AW-1:0] ea;
                ea = addr_q.pop_front();
                chk(mem_addr_o == ea, "R2", "request address", mem_addr_o, ea);
            end
        end
        if (rst_n && wr_en_o) begin
            if (idx_q.size() == 0) chk(0, "R4", "unexpected write", wr_idx_o, 0);
            else begin
                int ei;
                logic [DW-1:0] ed;
                ei = idx_q.pop_front();
                ed = dat_q.pop_front();
                chk(int'(wr_idx_o) == ei, "R4", "write index", wr_idx_o, ei);
                chk(wr_data_o == ed, "R4", "write data", wr_data_o, ed);
            end
        end
    end

    // Driver: pushes expectations, runs one burst, checks its completion
    task automatic run_case(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                            input int n, input int fk, input int lat_c, input bit poke);
        int nreq, nwr, exp_cnt, cyc;
        bit exp_trap;
        logic [CW-1:0] held;
        bit faulting;
        faulting = (fk >= 0 && fk < n);
        nreq = faulting ? fk + 1 : n;
        nwr  = faulting ? fk : n;
        exp_cnt  = faulting ? fk : n;
        exp_trap = faulting && fk == 0;
        for (int i = 0; i < nreq; i++) addr_q.push_back(base + stride * 32'(i));
        for (int i = 0; i < nwr; i++) begin
            idx_q.push_back(i);
            dat_q.push_back(mdata(base + stride * 32'(i)));
        end
        fault_en   = faulting;
        fault_addr = base + stride * 32'(fk);
        lat        = lat_c;
        @(negedge clk);
        start_i = 1'b1; base_addr_i = base; stride_i = stride; req_count_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            chk(done_o == 1'b1, "R8", "done one cycle after start", done_o, 1);
            chk(mem_req_o == 1'b0, "R8", "no request", mem_req_o, 0);
        end else begin
            chk(mem_req_o == 1'b1, "R1", "first request timing", mem_req_o, 1);
            chk(mem_addr_o == base, "R1", "first address", mem_addr_o, base);
        end
        cyc = 0;
        while (!done_o) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start_i = 1'b1; base_addr_i = 32'hDEAD_0000; req_count_i = '0; // R10
            end else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(int'(count_o) == exp_cnt, exp_trap ? "R6" : (faulting ? "R7" : "R5"),
            "final count", count_o, exp_cnt);
        chk(trap_o == exp_trap, exp_trap ? "R6" : "R7", "trap flag", trap_o, exp_trap);
        held = count_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done single pulse", done_o, 0);
        chk(addr_q.size() == 0, "R3", "requests outstanding in scoreboard", addr_q.size(), 0);
        chk(idx_q.size() == 0, "R4", "writes missing", idx_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(count_o == held && trap_o == exp_trap, "R9", "result held", count_o, held);
        if (poke) chk(int'(count_o) == exp_cnt, "R10", "start while busy ignored", count_o, exp_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_req_o == 0 && wr_en_o == 0 && done_o == 0, "R11", "reset outputs quiet",
            {mem_req_o, wr_en_o, done_o}, 0);
        chk(count_o == 0 && trap_o == 0, "R11", "reset results", {count_o, trap_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(32'h0000_1000, 32'd8, 4, -1, 1, 0);          // R5 full burst
        run_case(32'h0010_0007, 32'd1, 5, 4, 2, 0);           // R7 fault on element 4
        run_case(32'h0000_2000, 32'd16, 6, 0, 1, 0);          // R6 fault on element 0
        run_case(32'h0000_3000, 32'd4, 0, -1, 1, 0);          // R8 empty request
        run_case(32'h0000_4000, 32'hFFFF_FFF8, 3, -1, 3, 0);  // R2 negative stride
        run_case(32'hFFFF_FFF0, 32'd16, 3, -1, 1, 0);         // R2 address wrap
        run_case(32'h0000_5000, 32'd8, 7, 1, 1, 0);           // R7 fault on element 1
        run_case(32'h0000_6000, 32'd8, 6, -1, 2, 1);          // R10 start while busy
        run_case(32'h0000_7000, 32'd8, 1, -1, 4, 0);          // R5 single element
        finish_run();
    end
endmodule